// File: doc/BRIEF.md
# Comparator Event Pulse Filter

This block qualifies the output of a window comparator before it is allowed to raise an interrupt. Each channel gets a strobe when a conversion has been compared, together with a bit that says whether the sample fell inside the window. An inversion select turns each strobed result into either a positive or a negative event. A positive down counter must see a programmed number of positive events before it declares a pulse. A negative down counter restarts the positive count when enough opposing events arrive, so short spikes and noise do not add up into a false pulse.

When the pulse is declared, a sticky flag is set and both counters freeze. The flag can drive an interrupt through a per-channel enable. Software clears the flag with a write-one-to-clear strobe, which also restarts both counts. The channel count and both counter widths are parameters. Every channel runs on its own and shares only the clock and reset.

Top module: `cmp_pulse_filter`

## Requirements
- R1: On a strobe cycle, the event is positive when `in_range_i` equals `inv_sel_i` for that channel. With the select at 0, an outside result (0) is positive. With the select at 1, an inside result (1) is positive. Any other strobed result is a negative event.
- R2: Each positive event with the flag clear lowers `pos_cnt_o` by one on the next cycle.
- R3: When a positive event brings `pos_cnt_o` from 1 to 0, `flag_o` is 1 from the next cycle and `pos_cnt_o` reads 0. A positive reload of 0 behaves like 1, and the full-scale reload needs exactly that many events.
- R4: Once set, `flag_o` stays 1 until `clr_i` is pulsed for that channel.
- R5: While `flag_o` is 1, strobes have no effect: `pos_cnt_o` and `neg_cnt_o` keep their values.
- R6: `irq_o` is 1 exactly when `flag_o` and `irq_en_i` are both 1 for the channel. It follows the enable in the same cycle.
- R7: Each negative event with the flag clear lowers `neg_cnt_o` by one. The event that would bring it to 0 instead restarts both counters to their reload values on the next cycle.
- R8: A `clr_i` pulse makes `flag_o` 0 and reloads both counters on the next cycle. A strobe in the same cycle as `clr_i` is dropped, and the clear wins over a flag that would be set.
- R9: After reset, `flag_o` is 0 and the counters read their reload values.
- R10: Without a strobe or a clear, no count and no flag changes. A strobe or clear on one channel leaves every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | NUM_CH | Compare-done strobe, one bit per channel |
| in_range_i | input | NUM_CH | Comparator result, 1 = inside window |
| inv_sel_i | input | NUM_CH | Event polarity select per channel |
| pos_reload_i | input | NUM_CH*POS_W | Positive count reload values, channel 0 in the low bits |
| neg_reload_i | input | NUM_CH*NEG_W | Negative count reload values, channel 0 in the low bits |
| irq_en_i | input | NUM_CH | Interrupt enable per channel |
| clr_i | input | NUM_CH | Write-one-to-clear strobe per channel |
| flag_o | output | NUM_CH | Sticky pulse-detected flag |
| irq_o | output | NUM_CH | Interrupt request per channel |
| pos_cnt_o | output | NUM_CH*POS_W | Remaining positive events per channel |
| neg_cnt_o | output | NUM_CH*NEG_W | Remaining negative events before a restart |

## Verification
The bench builds the block with two channels, a 4-bit positive counter and a 3-bit negative counter. With these widths the full-scale reloads of 15 and 7 can be run down completely within a few dozen strobes, and the zero-reload corner is reached as well. Two channels are enough to drive opposite polarity selects side by side and to show that a strobe or clear on one channel leaves the other untouched. Every step is compared against a small model of the requirements for both channels.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_POS  = 2'd1,
    EV_NEG  = 2'd2
  } ev_kind_e;

  // positive when result matches polarity select
  function automatic ev_kind_e classify(input logic vld, input logic in_rng, input logic inv);
    if (!vld) return EV_NONE;
    return (in_rng == inv) ? EV_POS : EV_NEG;
  endfunction
endpackage

// File: rtl/cpf_event_map.sv
module cpf_event_map
  import cpf_pkg::*;
(
  input  logic     strobe_i,
  input  logic     in_range_i,
  input  logic     inv_sel_i,
  output ev_kind_e ev_o
);
  assign ev_o = classify(strobe_i, in_range_i, inv_sel_i);
endmodule

// File: rtl/cpf_down_ctr.sv
module cpf_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         step_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] remain_o,
  output logic         last_o
);
  // track events consumed; remaining = reload - consumed
  logic [W-1:0] used_q;
  logic [W:0]   used_inc;

  assign used_inc = {1'b0, used_q} + {{W{1'b0}}, 1'b1};
  assign last_o   = step_i && (used_inc >= {1'b0, reload_i});
  assign remain_o = (used_q >= reload_i) ? '0 : (reload_i - used_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            used_q <= '0;
    else if (restart_i)     used_q <= '0;
    else if (step_i && !used_inc[W]) used_q <= used_inc[W-1:0];
  end
endmodule

// File: rtl/cpf_channel.sv
module cpf_channel
  import cpf_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int NEG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             in_range_i,
  input  logic             inv_sel_i,
  input  logic [POS_W-1:0] pos_reload_i,
  input  logic [NEG_W-1:0] neg_reload_i,
  input  logic             irq_en_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic [POS_W-1:0] pos_cnt_o,
  output logic [NEG_W-1:0] neg_cnt_o
);
  ev_kind_e ev;
  logic     flag_q;
  logic     pos_step, neg_step;
  logic     pos_last, neg_last;
  logic     restart;

  cpf_event_map u_map (
    .strobe_i  (strobe_i),
    .in_range_i(in_range_i),
    .inv_sel_i (inv_sel_i),
    .ev_o      (ev)
  );

  // frozen while flagged; clear drops a same-cycle event
  assign pos_step = (ev == EV_POS) && !flag_q && !clr_i;
  assign neg_step = (ev == EV_NEG) && !flag_q && !clr_i;
  assign restart  = clr_i || neg_last;

  cpf_down_ctr #(.W(POS_W)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .step_i   (pos_step),
    .reload_i (pos_reload_i),
    .remain_o (pos_cnt_o),
    .last_o   (pos_last)
  );

  cpf_down_ctr #(.W(NEG_W)) u_neg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .step_i   (neg_step),
    .reload_i (neg_reload_i),
    .remain_o (neg_cnt_o),
    .last_o   (neg_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (clr_i)    flag_q <= 1'b0;
    else if (pos_last) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && irq_en_i;
endmodule

// File: rtl/cmp_pulse_filter.sv
module cmp_pulse_filter #(
  parameter int NUM_CH = 4,
  parameter int POS_W  = 8,
  parameter int NEG_W  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       strobe_i,
  input  logic [NUM_CH-1:0]       in_range_i,
  input  logic [NUM_CH-1:0]       inv_sel_i,
  input  logic [NUM_CH*POS_W-1:0] pos_reload_i,
  input  logic [NUM_CH*NEG_W-1:0] neg_reload_i,
  input  logic [NUM_CH-1:0]       irq_en_i,
  input  logic [NUM_CH-1:0]       clr_i,
  output logic [NUM_CH-1:0]       flag_o,
  output logic [NUM_CH-1:0]       irq_o,
  output logic [NUM_CH*POS_W-1:0] pos_cnt_o,
  output logic [NUM_CH*NEG_W-1:0] neg_cnt_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cpf_channel #(.POS_W(POS_W), .NEG_W(NEG_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .strobe_i    (strobe_i[c]),
      .in_range_i  (in_range_i[c]),
      .inv_sel_i   (inv_sel_i[c]),
      .pos_reload_i(pos_reload_i[c*POS_W +: POS_W]),
      .neg_reload_i(neg_reload_i[c*NEG_W +: NEG_W]),
      .irq_en_i    (irq_en_i[c]),
      .clr_i       (clr_i[c]),
      .flag_o      (flag_o[c]),
      .irq_o       (irq_o[c]),
      .pos_cnt_o   (pos_cnt_o[c*POS_W +: POS_W]),
      .neg_cnt_o   (neg_cnt_o[c*NEG_W +: NEG_W])
    );
  end
endmodule

// File: rtl/cmp_pulse_filter_chk.sv
module cmp_pulse_filter_chk #(
  parameter int NUM_CH = 4,
  parameter int POS_W  = 8,
  parameter int NEG_W  = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       strobe_i,
  input logic [NUM_CH-1:0]       irq_en_i,
  input logic [NUM_CH-1:0]       clr_i,
  input logic [NUM_CH*POS_W-1:0] pos_reload_i,
  input logic [NUM_CH*NEG_W-1:0] neg_reload_i,
  input logic [NUM_CH-1:0]       flag_o,
  input logic [NUM_CH-1:0]       irq_o,
  input logic [NUM_CH*POS_W-1:0] pos_cnt_o,
  input logic [NUM_CH*NEG_W-1:0] neg_cnt_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R3
    flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[c]) |-> (pos_cnt_o[c*POS_W +: POS_W] == '0));
    // R4
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[c] && !clr_i[c]) |=> flag_o[c]);
    // R5
    freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[c] && !clr_i[c]) ##1 $stable(neg_reload_i[c*NEG_W +: NEG_W])
        |-> $stable(neg_cnt_o[c*NEG_W +: NEG_W]));
    // R6
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (flag_o[c] && irq_en_i[c]));
    // R8
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[c] |=> !flag_o[c]);
    // R10
    idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strobe_i[c] && !clr_i[c] && !flag_o[c]) |=> !flag_o[c]);
  end
endmodule

bind cmp_pulse_filter cmp_pulse_filter_chk #(
  .NUM_CH(NUM_CH), .POS_W(POS_W), .NEG_W(NEG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strobe_i    (strobe_i),
  .irq_en_i    (irq_en_i),
  .clr_i       (clr_i),
  .pos_reload_i(pos_reload_i),
  .neg_reload_i(neg_reload_i),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .pos_cnt_o   (pos_cnt_o),
  .neg_cnt_o   (neg_cnt_o)
);

// File: tb/cmp_pulse_filter_tb.sv
`timescale 1ns/1ps
module cmp_pulse_filter_tb;
  localparam int NCH = 2;
  localparam int PW  = 4;
  localparam int NW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    strobe = '0, in_range = '0, inv_sel = '0, irq_en = '0, clr = '0;
  logic [NCH*PW-1:0] prl;
  logic [NCH*NW-1:0] nrl;
  logic [NCH-1:0]    flag, irq;
  logic [NCH*PW-1:0] pcnt;
  logic [NCH*NW-1:0] ncnt;

  int n_cmp = 0;
  int n_bad = 0;

  int e_pos [NCH];
  int e_neg [NCH];
  bit e_flag[NCH];
  int r_pos [NCH];
  int r_neg [NCH];

  always #2 clk = ~clk;

  cmp_pulse_filter #(.NUM_CH(NCH), .POS_W(PW), .NEG_W(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .in_range_i(in_range),
    .inv_sel_i(inv_sel), .pos_reload_i(prl), .neg_reload_i(nrl),
    .irq_en_i(irq_en), .clr_i(clr), .flag_o(flag), .irq_o(irq),
    .pos_cnt_o(pcnt), .neg_cnt_o(ncnt)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      cmp(req, $sformatf("ch%0d flag", c), int'(flag[c]), int'(e_flag[c]));
      cmp(req, $sformatf("ch%0d irq", c), int'(irq[c]), int'(e_flag[c] && irq_en[c]));
      cmp(req, $sformatf("ch%0d pos_cnt", c), int'(pcnt[c*PW +: PW]), e_pos[c]);
      cmp(req, $sformatf("ch%0d neg_cnt", c), int'(ncnt[c*NW +: NW]), e_neg[c]);
    end
  endtask

  task automatic set_reload(input int c, input int p, input int n);
    r_pos[c] = p;
    r_neg[c] = n;
    prl[c*PW +: PW] = PW'(p);
    nrl[c*NW +: NW] = NW'(n);
  endtask

  // model of one channel for one cycle
  task automatic model(input int c, input bit s, input bit inr, input bit cl);
    if (cl) begin
      e_flag[c] = 1'b0; e_pos[c] = r_pos[c]; e_neg[c] = r_neg[c];
    end else if (s && !e_flag[c]) begin
      if (inr == inv_sel[c]) begin
        if (e_pos[c] <= 1) begin e_pos[c] = 0; e_flag[c] = 1'b1; end
        else e_pos[c]--;
      end else begin
        if (e_neg[c] <= 1) begin e_pos[c] = r_pos[c]; e_neg[c] = r_neg[c]; end
        else e_neg[c]--;
      end
    end
  endtask

  // one cycle of stimulus, starting and ending at a negedge
  task automatic step(input logic [NCH-1:0] s, input logic [NCH-1:0] inr,
                      input logic [NCH-1:0] cl, input string req);
    strobe = s; in_range = inr; clr = cl;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) model(c, s[c], inr[c], cl[c]);
    strobe = '0; clr = '0;
    check_all(req);
  endtask

  task automatic reload_both(input string req);
    step('0, '0, '1, req);
  endtask

  task automatic t_reset();
    check_all("R9");
  endtask

  task automatic t_pos_count();
    irq_en = 2'b01;
    for (int i = 0; i < 4; i++) step(2'b01, 2'b00, '0, "R2");
    step(2'b01, 2'b00, '0, "R3");
    irq_en = 2'b00;
    #0.5; check_all("R6");
    irq_en = 2'b01;
    #0.5; check_all("R6");
  endtask

  task automatic t_sticky();
    step(2'b01, 2'b00, '0, "R5");
    step(2'b01, 2'b01, '0, "R5");
    for (int i = 0; i < 3; i++) step('0, '0, '0, "R4");
  endtask

  task automatic t_clear();
    step('0, '0, 2'b01, "R8");
    step('0, '0, '0, "R10");
  endtask

  task automatic t_neg_restart();
    step(2'b01, 2'b00, '0, "R2");
    step(2'b01, 2'b00, '0, "R2");
    step(2'b01, 2'b01, '0, "R7");
    step(2'b01, 2'b01, '0, "R7");
    step(2'b01, 2'b01, '0, "R7");
    step(2'b01, 2'b00, '0, "R7");
  endtask

  task automatic t_invert();
    inv_sel = 2'b10;
    step(2'b10, 2'b10, '0, "R1");
    step(2'b10, 2'b00, '0, "R1");
    step(2'b11, 2'b10, '0, "R1");
    step(2'b11, 2'b01, '0, "R10");
  endtask

  task automatic t_clear_wins();
    set_reload(1, 1, 2);
    reload_both("R8");
    irq_en = 2'b11;
    step(2'b10, 2'b10, 2'b10, "R8");
    step(2'b10, 2'b10, '0, "R3");
    step('0, '0, 2'b10, "R8");
  endtask

  task automatic t_extremes();
    set_reload(0, 15, 7);
    set_reload(1, 0, 0);
    reload_both("R9");
    for (int i = 0; i < 14; i++) step(2'b01, 2'b00, '0, "R2");
    step(2'b01, 2'b00, '0, "R3");
    step(2'b10, 2'b00, '0, "R7");
    step(2'b10, 2'b10, '0, "R3");
    reload_both("R8");
    for (int i = 0; i < 7; i++) step(2'b01, 2'b01, '0, "R7");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    set_reload(0, 5, 3);
    set_reload(1, 4, 2);
    for (int c = 0; c < NCH; c++) begin
      e_flag[c] = 1'b0; e_pos[c] = r_pos[c]; e_neg[c] = r_neg[c];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pos_count();
    t_sticky();
    t_clear();
    t_neg_restart();
    t_invert();
    t_clear_wins();
    t_extremes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule